// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-facing register slave of a single descriptor-driven DMA channel. It holds the channel status word, the command pointer and three condition-select words. It also provides a write-only control port. Each control write carries a 16-bit bit-enable in its upper half and a 16-bit data field in its lower half. Only the status bits that are enabled change. The block then derives the activity and error flags from the resulting bit values.

Three single-cycle pulses leave the block:

- A kick, which tells the descriptor sequencer that the channel is active.
- A flush request to the attached peripheral.
- A fetch request, raised when a new command pointer is accepted, with the aligned pointer presented alongside.

Descriptor fetching and data movement are handled elsewhere. All accesses are whole 32-bit words addressed by a word index.

Top module: `dbch_regfile`

## Requirements
- R1: After reset the status word, the command pointer and all three select words read 0, and no kick, flush or fetch pulse is present.
- R2: A write to word 0 (control) changes only the status bits whose enable bit (wdata[31:16]) is 1. Each such bit takes wdata[15:0] ANDed with the writable set: RUN bit 15, PAUSE bit 14, FLUSH bit 13, WAKE bit 12 and device bits 7:0. An enabled bit outside that set becomes 0. Status bits 31:16 and all disabled bits keep their value.
- R3: After a control write, if RUN or WAKE ends up set then ACTIVE (bit 10) is set. A set RUN also clears DEAD (bit 11).
- R4: After a control write with PAUSE set, ACTIVE is clear, whatever RUN or WAKE hold.
- R5: A control write that takes RUN from 1 to 0 clears ACTIVE and DEAD. If FLUSH is set at that moment, a flush pulse is issued and FLUSH is cleared.
- R6: In the cycle after a control write, kick is high if ACTIVE is set, and flush_req is high if FLUSH is still set. Both pulses last one cycle.
- R7: Reads of word 0 (control), word 2 (command pointer high) and any word index above 6 return 0. Writes to word 2 and to indices above 6 change nothing.
- R8: A write to word 3 (command pointer) is ignored while ACTIVE is set. An accepted write stores the value with bits 3:0 cleared and raises fetch_req for one cycle, with fetch_ptr equal to the stored value.
- R9: Word 1 (status), word 4 (interrupt select), word 5 (branch select) and word 6 (wait select) store a written word unchanged and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe; rdata is 0 when low |
| waddr | input | 6 | Word index within the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from waddr |
| status | output | 32 | Current status word for the sequencer |
| kick | output | 1 | One-cycle request to run the sequencer |
| flush_req | output | 1 | One-cycle flush request to the peripheral |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_ptr | output | 32 | Aligned command pointer |

## Verification
Register writes take effect at the clock edge that samples wr_en. The kick, flush and fetch pulses are registered at that same edge, so each is valid for exactly the following cycle. The bench drives each write on a falling edge and reads the pulses at the next falling edge, which is the middle of the pulse cycle. Read data is combinational, so the bench samples it a short delay after setting waddr, with no edge in between.

// File: rtl/dbch_pkg.sv
package dbch_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 6;
  localparam int NREG    = 7;
  localparam int ALIGN_B = 4;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_PHI  = 2;
  localparam int IDX_PLO  = 3;
  localparam int IDX_ISEL = 4;
  localparam int IDX_BSEL = 5;
  localparam int IDX_WSEL = 6;

  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;

  localparam logic [15:0] WRITABLE = 16'hF0FF;

  // masked merge of control value into the status word
  function automatic logic [REG_W-1:0] merge_ctrl(input logic [REG_W-1:0] old_s,
                                                  input logic [REG_W-1:0] ctrl);
    logic [15:0] en;
    logic [15:0] val;
    en  = ctrl[31:16];
    val = ctrl[15:0] & WRITABLE;
    return {old_s[31:16], (val & en) | (old_s[15:0] & ~en)};
  endfunction

  function automatic logic [REG_W-1:0] align_ptr(input logic [REG_W-1:0] p);
    return {p[REG_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
  endfunction
endpackage

// File: rtl/dbch_decode.sv
module dbch_decode #(
  parameter int IDX_W = 6,
  parameter int NREG  = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic [NREG-1:0]  sel
);
  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dbch_status_next.sv
module dbch_status_next
  import dbch_pkg::*;
(
  input  logic [REG_W-1:0] old_s,
  input  logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] new_s,
  output logic             run_fall,
  output logic             flush_evt,
  output logic             kick_evt
);
  logic [REG_W-1:0] s;
  logic             fl_on_stop;

  always_comb begin
    s = merge_ctrl(old_s, ctrl);
    if (s[B_WAKE]) s[B_ACTIVE] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACTIVE] = 1'b1;
      s[B_DEAD]   = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACTIVE] = 1'b0;
    run_fall   = old_s[B_RUN] & ~s[B_RUN];
    fl_on_stop = 1'b0;
    if (run_fall) begin
      s[B_ACTIVE] = 1'b0;
      s[B_DEAD]   = 1'b0;
      if (s[B_FLUSH]) begin
        fl_on_stop = 1'b1;
        s[B_FLUSH] = 1'b0;
      end
    end
    new_s     = s;
    kick_evt  = s[B_ACTIVE];
    flush_evt = fl_on_stop | s[B_FLUSH];
  end
endmodule

// File: rtl/dbch_readmux.sv
module dbch_readmux
  import dbch_pkg::*;
(
  input  logic             rd_en,
  input  logic [NREG-1:0]  sel,
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] ptr,
  input  logic [REG_W-1:0] isel,
  input  logic [REG_W-1:0] bsel,
  input  logic [REG_W-1:0] wsel,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel[IDX_CTRL] || sel[IDX_PHI]) rdata = '0;
      else if (sel[IDX_STAT])            rdata = stat;
      else if (sel[IDX_PLO])             rdata = ptr;
      else if (sel[IDX_ISEL])            rdata = isel;
      else if (sel[IDX_BSEL])            rdata = bsel;
      else if (sel[IDX_WSEL])            rdata = wsel;
    end
  end
endmodule

// File: rtl/dbch_regfile.sv
module dbch_regfile
  import dbch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [5:0]       waddr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [31:0]      status,
  output logic             kick,
  output logic             flush_req,
  output logic             fetch_req,
  output logic [31:0]      fetch_ptr
);
  logic [NREG-1:0]  sel;
  logic [REG_W-1:0] stat_q, ptr_q, isel_q, bsel_q, wsel_q;
  logic [REG_W-1:0] stat_ctrl;
  logic             run_fall, flush_evt, kick_evt;
  logic             ctrl_wr, ptr_wr, ptr_locked;

  dbch_decode #(.IDX_W(IDX_W), .NREG(NREG)) u_dec (.idx(waddr), .sel(sel));

  dbch_status_next u_snext (
    .old_s(stat_q), .ctrl(wdata), .new_s(stat_ctrl),
    .run_fall(run_fall), .flush_evt(flush_evt), .kick_evt(kick_evt)
  );

  assign ctrl_wr    = wr_en & sel[IDX_CTRL];
  assign ptr_locked = stat_q[B_ACTIVE];
  assign ptr_wr     = wr_en & sel[IDX_PLO] & ~ptr_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      ptr_q     <= '0;
      isel_q    <= '0;
      bsel_q    <= '0;
      wsel_q    <= '0;
      kick      <= 1'b0;
      flush_req <= 1'b0;
      fetch_req <= 1'b0;
    end else begin
      kick      <= ctrl_wr & kick_evt;
      flush_req <= ctrl_wr & flush_evt;
      fetch_req <= ptr_wr;
      if (ctrl_wr)                 stat_q <= stat_ctrl;
      if (wr_en && sel[IDX_STAT])  stat_q <= wdata;
      if (ptr_wr)                  ptr_q  <= align_ptr(wdata);
      if (wr_en && sel[IDX_ISEL])  isel_q <= wdata;
      if (wr_en && sel[IDX_BSEL])  bsel_q <= wdata;
      if (wr_en && sel[IDX_WSEL])  wsel_q <= wdata;
    end
  end

  dbch_readmux u_rmux (
    .rd_en(rd_en), .sel(sel), .stat(stat_q), .ptr(ptr_q),
    .isel(isel_q), .bsel(bsel_q), .wsel(wsel_q), .rdata(rdata)
  );

  assign status    = stat_q;
  assign fetch_ptr = ptr_q;

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr == 6'(IDX_CTRL)) |-> rdata == '0); // R7
  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == 6'(IDX_PLO) && status[B_ACTIVE]) |=> $stable(fetch_ptr) && !fetch_req); // R8
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ptr[ALIGN_B-1:0] == '0); // R8
  AST_RUN_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == 6'(IDX_CTRL)) |=> !(status[B_RUN] && status[B_DEAD])); // R3
  AST_PAUSE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == 6'(IDX_CTRL)) |=> !(status[B_PAUSE] && status[B_ACTIVE])); // R4
  AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> status[B_ACTIVE]); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (kick || flush_req) |-> $past(wr_en)); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[B_RUN]) && $past(wr_en && waddr == 6'(IDX_CTRL))) |->
      !status[B_ACTIVE] && !status[B_DEAD] && !status[B_FLUSH]); // R5
endmodule

// File: tb/test_dbch_regfile.sv
module test_dbch_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status, fetch_ptr;
  logic        kick, flush_req, fetch_req;

  int n_chk = 0;
  int n_fail = 0;
  logic got_kick, got_flush, got_fetch;

  always #4 clk = ~clk;

  dbch_regfile i_dbch_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
    .wdata(wdata), .rdata(rdata), .status(status), .kick(kick),
    .flush_req(flush_req), .fetch_req(fetch_req), .fetch_ptr(fetch_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    got_kick = kick; got_flush = flush_req; got_fetch = fetch_req;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; waddr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'd1, v); chk("R1 status", v, 32'h0);
    rd(6'd3, v); chk("R1 ptr", v, 32'h0);
    rd(6'd4, v); chk("R1 isel", v, 32'h0);
    rd(6'd6, v); chk("R1 wsel", v, 32'h0);
    chk("R1 pulses", {29'h0, kick, flush_req, fetch_req}, 32'h0);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    wr(6'd1, 32'h5A5A_0000);
    wr(6'd0, 32'h00FF_0011);
    rd(6'd1, v); chk("R2 upper kept", v, 32'h5A5A_0011);
    wr(6'd1, 32'h0);
    wr(6'd0, 32'h00FF_00A5);
    rd(6'd1, v); chk("R2 low bits", v, 32'h0000_00A5);
    wr(6'd0, 32'h000F_0000);
    rd(6'd1, v); chk("R2 partial mask", v, 32'h0000_00A0);
    wr(6'd0, 32'h0400_0400);
    rd(6'd1, v); chk("R2 non-writable", v, 32'h0000_00A0);
    chk("R6 no kick idle", {31'h0, got_kick}, 32'h0);
  endtask

  task automatic t_run_pause;
    logic [31:0] v;
    wr(6'd1, 32'h0000_0800);
    wr(6'd0, 32'h8000_8000);
    chk("R6 kick on run", {31'h0, got_kick}, 32'h1);
    rd(6'd1, v); chk("R3 run active no dead", v, 32'h0000_8400);
    wr(6'd3, 32'h0000_1234);
    chk("R8 no fetch locked", {31'h0, got_fetch}, 32'h0);
    rd(6'd3, v); chk("R8 ptr locked", v, 32'h0);
    wr(6'd0, 32'h4000_4000);
    chk("R4 no kick paused", {31'h0, got_kick}, 32'h0);
    rd(6'd1, v); chk("R4 pause clears active", v, 32'h0000_C000);
    wr(6'd3, 32'h0000_1237);
    chk("R8 fetch pulse", {31'h0, got_fetch}, 32'h1);
    chk("R8 fetch_ptr", fetch_ptr, 32'h0000_1230);
    rd(6'd3, v); chk("R8 aligned", v, 32'h0000_1230);
  endtask

  task automatic t_flush_stop;
    logic [31:0] v;
    wr(6'd0, 32'h6000_2000);
    chk("R6 kick", {31'h0, got_kick}, 32'h1);
    chk("R6 flush held", {31'h0, got_flush}, 32'h1);
    rd(6'd1, v); chk("R3 run flush", v, 32'h0000_A400);
    wr(6'd0, 32'h8000_0000);
    chk("R5 flush on stop", {31'h0, got_flush}, 32'h1);
    chk("R5 no kick", {31'h0, got_kick}, 32'h0);
    rd(6'd1, v); chk("R5 stop clears", v, 32'h0);
    wr(6'd0, 32'h1000_1000);
    chk("R3 wake kick", {31'h0, got_kick}, 32'h1);
    rd(6'd1, v); chk("R3 wake active", v, 32'h0000_1400);
    wr(6'd1, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    rd(6'd0, v); chk("R7 ctrl read", v, 32'h0);
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd2, v); chk("R7 ptr high", v, 32'h0);
    wr(6'd9, 32'hFFFF_FFFF);
    rd(6'd9, v); chk("R7 unused", v, 32'h0);
    rd(6'd3, v); chk("R7 ptr untouched", v, 32'h0000_1230);
    wr(6'd4, 32'h000F_0005);
    wr(6'd5, 32'h0003_0001);
    wr(6'd6, 32'hDEAD_BEEF);
    rd(6'd4, v); chk("R9 isel", v, 32'h000F_0005);
    rd(6'd5, v); chk("R9 bsel", v, 32'h0003_0001);
    rd(6'd6, v); chk("R9 wsel", v, 32'hDEAD_BEEF);
    wr(6'd1, 32'h1357_2468);
    rd(6'd1, v); chk("R9 status", v, 32'h1357_2468);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked();
    t_run_pause();
    t_flush_stop();
    t_misc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule